// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Controller

This block gathers peripheral request lines into a small set of groups and drives a single request toward a host CPU. Two groups, the card-slot events and the external I/O pins, each have a second tier: a status register that latches rising edges of its inputs, and one enable register holding a status-enable mask and an interrupt-enable mask. The remaining sources (two slot status-change lines, display, USB, USB wake and system management) feed the first-level summary directly. The last three are gated by an interrupt enable; the first three have no enable.

A summary register shows one bit per group. A global gate register decides whether a pending summary reaches the CPU line. The CPU side treats the request as edge-sensitive. The output stage is a three-state machine: ST_IDLE (line low), ST_FIRE (line high) and ST_GAP (a forced one-cycle low). The transitions are: ST_IDLE to ST_FIRE when the gate is open and something is pending. ST_FIRE to ST_IDLE when the gate closes or nothing is pending. ST_FIRE to ST_GAP when software writes the gate bit to 1 while it is already 1. ST_GAP to ST_FIRE if the request is still qualified, otherwise to ST_IDLE. Software always gets a fresh rising edge after it re-opens the gate.

Registers are read combinationally and written on the clock edge through a simple word-addressed port. Writes to the second-level status registers clear the bits written as 1.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `cpu_irq` is low.
- R2: Enable registers read back what was written, with unused bits reading 0. The offsets are: 1 gate (bit 0), 3 card-slot enables (status-enable in bits 3:0, interrupt-enable in bits 11:8), 5 external enables (status-enable in bits 5:0, interrupt-enable in bits 13:8), and 6 direct enables (bit 0 USB, bit 1 USB wake, bit 2 system management). Offset 7 reads 0 and ignores writes.
- R3: A second-level status bit (offset 2 card-slot bits 3:0, offset 4 external bits 5:0) sets on a rising edge of its synchronised input only while its status-enable bit is 1.
- R4: Writing 1 to a second-level status bit clears it. Writing 0 leaves it unchanged.
- R5: A status set and a clear write to the same bit in the same cycle leave the bit set.
- R6: Summary bit 0 (card-slot) and bit 1 (external) are the OR over that group of status AND interrupt-enable.
- R7: Summary bits 2, 3 and 4 follow the synchronised slot-1 change, slot-2 change and display inputs with no enable. Bits 5, 6 and 7 follow USB, USB wake and system management only when their offset-6 enables are set.
- R8: `cpu_irq` rises one cycle after the gate is 1 and any summary bit is 1. It is low whenever the gate was 0 or nothing was pending in the previous cycle.
- R9: Writing the gate bit to 1 while the request is already high drops `cpu_irq` for exactly one cycle and then raises it again. Reopening the gate from 0 with a request pending gives a new rising edge.
- R10: A second-level input held high after its edge has been acknowledged does not set the status again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| slot_in | input | 4 | Slot-1 I/O, slot-1 ring, slot-2 I/O, slot-2 ring (bits 0..3) |
| ext_in | input | 6 | External pins: bits 3:0 first bank, bits 5:4 second bank |
| dir_in | input | 6 | Slot-1 change, slot-2 change, display, USB, USB wake, system management (bits 0..5) |
| cpu_irq | output | 1 | Request to the CPU |

## Verification
The hardest case to reach is a status set that lands in the same clock edge as the software clear of that bit. The input edge has to be timed through the two-flop synchroniser and the edge detector. The bench raises the input on a falling edge and issues the clear write exactly two cycles later, so that the write commits on the edge where the detected rise is present. The re-arm gap is reached in a similar way: the gate is written to 1 while the request is already high, and the rising edges of `cpu_irq` are counted.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
    localparam int OFF_SUM   = 0;
    localparam int OFF_GATE  = 1;
    localparam int OFF_SLOTS = 2;
    localparam int OFF_SLOTE = 3;
    localparam int OFF_EXTS  = 4;
    localparam int OFF_EXTE  = 5;
    localparam int OFF_DIRE  = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_GAP  = 2'd2
    } out_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pipe[STAGES-1];
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W  = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rise,
    input  logic          we_stat,
    input  logic          we_en,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  stat,
    output logic [W-1:0]  sen,
    output logic [W-1:0]  ien,
    output logic          sum_bit
);
    localparam int IEN_LSB = DW / 2;

    logic [W-1:0] clr;

    assign clr = we_stat ? wdata[W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            sen  <= '0;
            ien  <= '0;
        end else begin
            // set has priority over a same-cycle acknowledge
            stat <= (stat & ~clr) | (rise & sen);
            if (we_en) begin
                sen <= wdata[W-1:0];
                ien <= wdata[IEN_LSB +: W];
            end
        end
    end

    assign sum_bit = |(stat & ien);
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import grp_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate,
    input  logic       pending,
    input  logic       rearm,
    output out_state_e state,
    output logic       irq
);
    out_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (gate && pending) nxt = ST_FIRE;
            ST_FIRE: begin
                if (!gate || !pending) nxt = ST_IDLE;
                else if (rearm)        nxt = ST_GAP;
            end
            ST_GAP:  nxt = (gate && pending) ? ST_FIRE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        irq = (state == ST_FIRE);
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
    import grp_irq_pkg::*;
#(
    parameter int SLOT_N      = 4,
    parameter int EXT_N       = 6,
    parameter int DIR_N       = 6,
    parameter int NOEN_N      = 3,
    parameter int AW          = 3,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [SLOT_N-1:0] slot_in,
    input  logic [EXT_N-1:0]  ext_in,
    input  logic [DIR_N-1:0]  dir_in,
    output logic              cpu_irq
);
    localparam int IE_N    = DIR_N - NOEN_N;
    localparam int SUM_N   = 2 + DIR_N;
    localparam int IEN_LSB = DW / 2;

    logic [SLOT_N-1:0] slot_rise, slot_lvl, slot_stat, slot_sen, slot_ien;
    logic [EXT_N-1:0]  ext_rise, ext_lvl, ext_stat, ext_sen, ext_ien;
    logic [DIR_N-1:0]  dir_lvl, dir_rise;
    logic [IE_N-1:0]   dir_ie;
    logic              gate_q, slot_sum, ext_sum, pending, rearm;
    logic [SUM_N-1:0]  summary;
    out_state_e        state;

    function automatic logic hit(input logic [AW-1:0] a, input int off);
        return reg_we && (a == AW'(off));
    endfunction

    irq_sync #(.W(SLOT_N), .STAGES(SYNC_STAGES)) u_sync_slot (
        .clk(clk), .rst_n(rst_n), .din(slot_in), .lvl(slot_lvl), .rise(slot_rise));
    irq_sync #(.W(EXT_N), .STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .din(ext_in), .lvl(ext_lvl), .rise(ext_rise));
    irq_sync #(.W(DIR_N), .STAGES(SYNC_STAGES)) u_sync_dir (
        .clk(clk), .rst_n(rst_n), .din(dir_in), .lvl(dir_lvl), .rise(dir_rise));

    irq_group #(.W(SLOT_N), .DW(DW)) u_slot (
        .clk(clk), .rst_n(rst_n), .rise(slot_rise),
        .we_stat(hit(reg_addr, OFF_SLOTS)), .we_en(hit(reg_addr, OFF_SLOTE)),
        .wdata(reg_wdata), .stat(slot_stat), .sen(slot_sen), .ien(slot_ien),
        .sum_bit(slot_sum));

    irq_group #(.W(EXT_N), .DW(DW)) u_ext (
        .clk(clk), .rst_n(rst_n), .rise(ext_rise),
        .we_stat(hit(reg_addr, OFF_EXTS)), .we_en(hit(reg_addr, OFF_EXTE)),
        .wdata(reg_wdata), .stat(ext_stat), .sen(ext_sen), .ien(ext_ien),
        .sum_bit(ext_sum));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            dir_ie <= '0;
        end else begin
            if (hit(reg_addr, OFF_GATE)) gate_q <= reg_wdata[0];
            if (hit(reg_addr, OFF_DIRE)) dir_ie <= reg_wdata[IE_N-1:0];
        end
    end

    assign summary = {dir_lvl & {dir_ie, {NOEN_N{1'b1}}}, ext_sum, slot_sum};
    assign pending = |summary;
    assign rearm   = hit(reg_addr, OFF_GATE) && reg_wdata[0] && gate_q;

    irq_out_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .gate(gate_q), .pending(pending),
        .rearm(rearm), .state(state), .irq(cpu_irq));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(OFF_SUM):   reg_rdata = DW'(summary);
            AW'(OFF_GATE):  reg_rdata = DW'(gate_q);
            AW'(OFF_SLOTS): reg_rdata = DW'(slot_stat);
            AW'(OFF_SLOTE): reg_rdata = DW'(slot_sen) | (DW'(slot_ien) << IEN_LSB);
            AW'(OFF_EXTS):  reg_rdata = DW'(ext_stat);
            AW'(OFF_EXTE):  reg_rdata = DW'(ext_sen) | (DW'(ext_ien) << IEN_LSB);
            AW'(OFF_DIRE):  reg_rdata = DW'(dir_ie);
            default:        reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk
    import grp_irq_pkg::*;
#(
    parameter int SLOT_N = 4,
    parameter int AW     = 3,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_irq,
    input logic              gate_q,
    input logic              pending,
    input logic              rearm,
    input out_state_e        state,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [SLOT_N-1:0] slot_stat,
    input logic [SLOT_N-1:0] slot_sen,
    input logic [SLOT_N-1:0] slot_rise
);
    p_gate_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> !cpu_irq);

    p_quiet_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !cpu_irq);

    p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(gate_q && pending));

    p_gap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (state != ST_GAP));

    p_rearm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && state == ST_FIRE) |=> !cpu_irq);

    p_sen_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_stat & ~$past(slot_stat)) & ~$past(slot_sen)) == '0);

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == AW'(OFF_SLOTS) && slot_rise == '0)
        |=> ((slot_stat & $past(reg_wdata[SLOT_N-1:0])) == '0));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(slot_rise & slot_sen))
        |=> ((slot_stat & $past(slot_rise & slot_sen)) == $past(slot_rise & slot_sen)));
endmodule

bind grp_irq_ctrl grp_irq_chk #(.SLOT_N(SLOT_N), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .gate_q(gate_q),
    .pending(pending), .rearm(rearm), .state(state), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .slot_stat(slot_stat),
    .slot_sen(slot_sen), .slot_rise(slot_rise));

// File: tb/grp_irq_ctrl_test.sv
`timescale 1ns/1ps
module grp_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  slot_in = '0;
    logic [5:0]  ext_in = '0;
    logic [5:0]  dir_in = '0;
    logic        cpu_irq;

    int n_run = 0;
    int n_fail = 0;
    int rise_cnt = 0;
    logic irq_prev = 1'b0;

    always #10 clk = ~clk;

    grp_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_in(slot_in),
        .ext_in(ext_in), .dir_in(dir_in), .cpu_irq(cpu_irq));

    always @(negedge clk) begin
        if (cpu_irq && !irq_prev) rise_cnt++;
        irq_prev = cpu_irq;
    end

    // {write, offset, data, expected read}
    localparam int NV = 22;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 3'd0, 16'h0000, 16'h0000},
        {1'b0, 3'd1, 16'h0000, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0000},
        {1'b1, 3'd3, 16'h0F0F, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0F0F},
        {1'b1, 3'd5, 16'h3F3F, 16'h0000},
        {1'b0, 3'd5, 16'h0000, 16'h3F3F},
        {1'b1, 3'd5, 16'hFFFF, 16'h0000},
        {1'b0, 3'd5, 16'h0000, 16'h3F3F},
        {1'b1, 3'd6, 16'hFFFF, 16'h0000},
        {1'b0, 3'd6, 16'h0000, 16'h0007},
        {1'b1, 3'd1, 16'hFFFF, 16'h0000},
        {1'b0, 3'd1, 16'h0000, 16'h0001},
        {1'b0, 3'd7, 16'h0000, 16'h0000},
        {1'b1, 3'd7, 16'hFFFF, 16'h0000},
        {1'b0, 3'd7, 16'h0000, 16'h0000},
        {1'b1, 3'd1, 16'h0000, 16'h0000},
        {1'b1, 3'd6, 16'h0000, 16'h0000},
        {1'b1, 3'd3, 16'h0000, 16'h0000},
        {1'b1, 3'd5, 16'h0000, 16'h0000},
        {1'b0, 3'd3, 16'h0000, 16'h0000},
        {1'b0, 3'd1, 16'h0000, 16'h0000}
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_run++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: offset %0d read %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        int rc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cpu_irq, 1'b0, "R1 irq after reset");

        // R1/R2 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][35]) wr(VEC[i][34:32], VEC[i][31:16]);
            else            rd(VEC[i][34:32], VEC[i][15:0], "R2 table");
        end

        // R3: latch with status-enable only; R6: no summary without ien
        wr(3, 16'h000F);
        @(negedge clk); slot_in[1] = 1'b1;
        idle(5); slot_in[1] = 1'b0; idle(3);
        rd(2, 16'h0002, "R3 latch with sen");
        rd(0, 16'h0000, "R6 summary masked by ien");
        wr(3, 16'h0F0F);
        rd(0, 16'h0001, "R6 slot summary bit0");

        // R3: no latch with sen cleared for bit0
        wr(3, 16'h0E0E);
        @(negedge clk); slot_in[0] = 1'b1;
        idle(5); slot_in[0] = 1'b0; idle(3);
        rd(2, 16'h0002, "R3 no latch without sen");

        // R4: write-one-to-clear
        wr(2, 16'h0001);
        rd(2, 16'h0002, "R4 zero write keeps bit");
        wr(2, 16'h0002);
        rd(2, 16'h0000, "R4 one write clears bit");

        // R10: held input does not relatch
        wr(3, 16'h0F0F);
        @(negedge clk); slot_in[2] = 1'b1;
        idle(5);
        rd(2, 16'h0004, "R10 first edge latched");
        wr(2, 16'h0004);
        idle(5);
        rd(2, 16'h0000, "R10 no relatch on level");
        slot_in[2] = 1'b0;
        idle(3);

        // R5: set and clear in the same cycle
        @(negedge clk); slot_in[3] = 1'b1;
        @(negedge clk);
        wr(2, 16'h0008);
        rd(2, 16'h0008, "R5 set wins over clear");
        slot_in[3] = 1'b0;
        wr(2, 16'h000F);
        wr(3, 16'h0000);
        rd(0, 16'h0000, "R6 slot summary cleared");

        // external group
        wr(5, 16'h2020);
        @(negedge clk); ext_in[5] = 1'b1;
        idle(5); ext_in[5] = 1'b0; idle(3);
        rd(4, 16'h0020, "R3 external latch");
        rd(0, 16'h0002, "R6 external summary bit1");

        // R8: gate
        idle(2); #1;
        chk(cpu_irq, 1'b0, "R8 gate closed blocks irq");
        rc = rise_cnt;
        wr(1, 16'h0001);
        idle(2); #1;
        chk(cpu_irq, 1'b1, "R8 irq with gate open");
        chk_int(rise_cnt, rc + 1, "R9 edge on gate open");
        wr(1, 16'h0000);
        idle(2); #1;
        chk(cpu_irq, 1'b0, "R8 irq drops on gate close");

        // R9: reopen and rearm
        rc = rise_cnt;
        wr(1, 16'h0001);
        idle(3); #1;
        chk_int(rise_cnt, rc + 1, "R9 new edge on reopen");
        rc = rise_cnt;
        wr(1, 16'h0001);
        idle(3); #1;
        chk_int(rise_cnt, rc + 1, "R9 rearm edge while high");
        chk(cpu_irq, 1'b1, "R9 irq high after rearm");

        // R8: acknowledge removes request
        wr(4, 16'h0020);
        idle(2); #1;
        chk(cpu_irq, 1'b0, "R8 irq low when nothing pending");
        wr(1, 16'h0000);

        // R7: direct sources
        dir_in = 6'b000111;
        idle(4);
        rd(0, 16'h001C, "R7 unmasked direct sources");
        dir_in = 6'b111000;
        idle(4);
        rd(0, 16'h0000, "R7 masked direct sources");
        wr(6, 16'h0005);
        rd(0, 16'h00A0, "R7 enabled direct sources");
        dir_in = '0;
        idle(4);
        rd(0, 16'h0000, "R7 direct sources released");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule